// File: doc/BRIEF.md
# Multi-Word Register Store Sequencer

This block carries out a block store of general registers to memory. A single start strobe names a first register, a base register selector with its value, and a 16-bit signed displacement. The block then walks every register from the named one up to the highest, register 31. For each register it writes the low 32 bits to memory, in consecutive ascending word addresses.

Each register-file read is issued one cycle ahead of its use, so a register file with a synchronous read port can feed the sequence. A write is held on the memory port until that port accepts it. With a port that is always ready, the block sustains one word per cycle. When the whole block store is done, the block gives a one-cycle completion pulse.

A start given while the core runs in little-endian byte order stores nothing. Instead, the block raises a one-cycle alignment-exception pulse for the trap logic. No other state is changed.

Top module: `multiword_store_seq`

## Requirements
- R1: The first write address equals the sign-extended 16-bit displacement plus the base value. The base value is replaced by zero when the base selector is 0.
- R2: A start with first register n produces exactly 32-n write handshakes, for registers n through 31 in ascending order.
- R3: The data of each write is bits 31:0 of the register being stored, as returned by the register file one cycle after its read address.
- R4: Each write address is the previous one plus 4, wrapping modulo 2^64.
- R5: While a write is offered and wr_ready_i is low, wr_valid_o stays high and wr_addr_o stays unchanged in the next cycle.
- R6: A start with little_end_i high causes no write. align_exc_o is high for exactly the one cycle after that start.
- R7: done_o is high for exactly the one cycle after the handshake for register 31, and low at all other times.
- R8: A first register of 31 produces exactly one write.
- R9: A start strobe received while a sequence is in progress is ignored. The running sequence is unchanged, and no further writes follow it.
- R10: During and right after reset, wr_valid_o, done_o and align_exc_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| first_reg_i | input | 5 | Number of the first register to store |
| base_sel_i | input | 5 | Base register selector; 0 means a base of zero |
| base_val_i | input | 64 | Value of the selected base register |
| disp_i | input | 16 | Signed displacement |
| little_end_i | input | 1 | Core is in little-endian mode |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | 64 | Register-file read data, one cycle after the address |
| wr_valid_o | output | 1 | Memory write request valid |
| wr_addr_o | output | 64 | Memory write byte address |
| wr_data_o | output | 32 | Memory write word |
| wr_ready_i | input | 1 | Memory port accepts the current write |
| done_o | output | 1 | One-cycle pulse after the final write is accepted |
| align_exc_o | output | 1 | One-cycle alignment-exception pulse |

## Verification
A corrupted register index shows up at the very next accepted write, as a word from the wrong register. It also shows up as a wrong number of beats, or as done_o at the wrong time. A corrupted address register shows up as a write address that breaks the plus-four progression on the next handshake. A wrong state bit shows up within one cycle, as a write request that appears after an exception or an ignored start, or as a request that drops while stalled. The stimulus mixes always-ready, pseudo-random and every-other-cycle ready patterns. This lets stalls land on every beat position, including the last.

// File: rtl/mws_pkg.sv
package mws_pkg;
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_STORE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mws_ea_calc.sv
module mws_ea_calc #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  base_sel_i,
    input  logic [XLEN-1:0]   base_val_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [XLEN-1:0]   ea_o
);
    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] disp_ext;

    always_comb begin
        base_eff = (base_sel_i == '0) ? '0 : base_val_i;
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        ea_o     = base_eff + disp_ext;
    end
endmodule

// File: rtl/mws_ctrl.sv
module mws_ctrl
    import mws_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREGS  = 32,
    parameter int WORD_W = 32,
    parameter int IDX_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              little_end_i,
    input  logic [IDX_W-1:0]  first_reg_i,
    input  logic [XLEN-1:0]   ea_i,
    output logic [IDX_W-1:0]  rf_raddr_o,
    input  logic [XLEN-1:0]   rf_rdata_i,
    output logic              wr_valid_o,
    output logic [XLEN-1:0]   wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ready_i,
    output logic              done_o,
    output logic              align_exc_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREGS - 1);
    localparam logic [XLEN-1:0]  STEP     = XLEN'(WORD_W / 8);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  addr;
        logic             done;
        logic             exc;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;
    logic at_last;

    always_comb begin
        accept     = (seq_q.state == SEQ_STORE) && wr_ready_i;
        at_last    = (seq_q.idx == LAST_IDX);
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.exc  = 1'b0;
        rf_raddr_o = seq_q.idx;
        case (seq_q.state)
            SEQ_IDLE: begin
                rf_raddr_o = first_reg_i;
                if (start_i) begin
                    if (little_end_i) begin
                        seq_d.exc = 1'b1;
                    end else begin
                        seq_d.state = SEQ_STORE;
                        seq_d.idx   = first_reg_i;
                        seq_d.addr  = ea_i;
                    end
                end
            end
            SEQ_STORE: begin
                if (accept) begin
                    if (at_last) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx  = seq_q.idx + 1'b1;
                        seq_d.addr = seq_q.addr + STEP;
                        rf_raddr_o = seq_q.idx + 1'b1;
                    end
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.idx   <= '0;
            seq_q.addr  <= '0;
            seq_q.done  <= 1'b0;
            seq_q.exc   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_valid_o  = (seq_q.state == SEQ_STORE);
    assign wr_addr_o   = seq_q.addr;
    assign wr_data_o   = rf_rdata_i[WORD_W-1:0];
    assign done_o      = seq_q.done;
    assign align_exc_o = seq_q.exc;

    // R5: a stalled request holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)));

    // R4: address advances by one word per accepted beat
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i && !at_last) |=>
        (wr_valid_o && (wr_addr_o == $past(wr_addr_o) + STEP)));

    // R2: register index advances in ascending order
    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i && !at_last) |=>
        (rf_raddr_o == $past(rf_raddr_o) || seq_q.idx == $past(seq_q.idx) + 1'b1));

    // R7: done follows an accepted beat and never overlaps a request
    a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_valid_o && wr_ready_i) && !wr_valid_o));

    // R6: exception only after a little-endian start, with no write
    a_r6_exc: assert property (@(posedge clk) disable iff (!rst_n)
        align_exc_o |-> ($past(start_i && little_end_i) && !wr_valid_o));

    // R10: outputs quiet while reset is applied
    always_comb begin
        if (!rst_n) begin
            a_r10_reset: assert (!wr_valid_o && !done_o && !align_exc_o);
        end
    end
endmodule

// File: rtl/multiword_store_seq.sv
module multiword_store_seq #(
    parameter int XLEN   = 64,
    parameter int NREGS  = 32,
    parameter int WORD_W = 32,
    parameter int DISP_W = 16,
    parameter int IDX_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  first_reg_i,
    input  logic [IDX_W-1:0]  base_sel_i,
    input  logic [XLEN-1:0]   base_val_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              little_end_i,
    output logic [IDX_W-1:0]  rf_raddr_o,
    input  logic [XLEN-1:0]   rf_rdata_i,
    output logic              wr_valid_o,
    output logic [XLEN-1:0]   wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ready_i,
    output logic              done_o,
    output logic              align_exc_o
);
    logic [XLEN-1:0] ea;

    mws_ea_calc #(
        .XLEN   (XLEN),
        .DISP_W (DISP_W),
        .IDX_W  (IDX_W)
    ) u_ea (
        .base_sel_i (base_sel_i),
        .base_val_i (base_val_i),
        .disp_i     (disp_i),
        .ea_o       (ea)
    );

    mws_ctrl #(
        .XLEN   (XLEN),
        .NREGS  (NREGS),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .little_end_i (little_end_i),
        .first_reg_i  (first_reg_i),
        .ea_i         (ea),
        .rf_raddr_o   (rf_raddr_o),
        .rf_rdata_i   (rf_rdata_i),
        .wr_valid_o   (wr_valid_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .wr_ready_i   (wr_ready_i),
        .done_o       (done_o),
        .align_exc_o  (align_exc_o)
    );
endmodule

// File: tb/multiword_store_seq_test.sv
`timescale 1ns/1ps
module multiword_store_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  first_reg_i = '0;
    logic [4:0]  base_sel_i = '0;
    logic [63:0] base_val_i = '0;
    logic [15:0] disp_i = '0;
    logic        little_end_i = 1'b0;
    logic [4:0]  rf_raddr_o;
    logic [63:0] rf_rdata_i;
    logic        wr_valid_o;
    logic [63:0] wr_addr_o;
    logic [31:0] wr_data_o;
    logic        wr_ready_i = 1'b0;
    logic        done_o;
    logic        align_exc_o;

    int checks = 0;
    int errors = 0;
    int beats = 0;
    int done_seen = 0;
    bit done_pending = 0;
    bit hold_pending = 0;
    logic [63:0] hold_addr;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA7;
    bit finished = 0;

    typedef struct {
        logic [63:0] a;
        logic [31:0] d;
        bit          last;
    } exp_t;
    exp_t expq[$];

    logic [63:0] regs [32];

    always #4 clk = ~clk;

    multiword_store_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_reg_i(first_reg_i),
        .base_sel_i(base_sel_i), .base_val_i(base_val_i), .disp_i(disp_i),
        .little_end_i(little_end_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ready_i(wr_ready_i), .done_o(done_o), .align_exc_o(align_exc_o)
    );

    function automatic logic [63:0] reg_val(input int i);
        reg_val = {32'hBEEF_0000 | 32'(i), 32'h1357_0000 + 32'(i) * 32'h0001_0203};
    endfunction

    // synchronous-read register file model
    always @(posedge clk) rf_rdata_i <= regs[rf_raddr_o];

    // ready driver, away from the sampling edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0: wr_ready_i = 1'b1;
            1: wr_ready_i = lfsr[0];
            default: wr_ready_i = ~wr_ready_i;
        endcase
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_pending) begin
                check(done_o == 1'b1, "R7", "done after last beat", 64'(done_o), 64'd1);
                done_pending = 0;
                done_seen++;
            end else if (done_o) begin
                check(1'b0, "R7", "unexpected done", 64'(done_o), 64'd0);
            end
            if (hold_pending) begin
                check(wr_valid_o && wr_addr_o == hold_addr, "R5", "stalled request held",
                      wr_addr_o, hold_addr);
                hold_pending = 0;
            end
            if (wr_valid_o && !wr_ready_i) begin
                hold_pending = 1;
                hold_addr = wr_addr_o;
            end
            if (wr_valid_o && wr_ready_i) begin
                beats++;
                if (expq.size() == 0) begin
                    check(1'b0, "R9", "write with nothing expected", wr_addr_o, 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(wr_addr_o == e.a, "R1", "R4 write address", wr_addr_o, e.a);
                    check(wr_data_o == e.d, "R3", "write data", 64'(wr_data_o), 64'(e.d));
                    if (e.last) done_pending = 1;
                end
            end
        end
    end

    task automatic run_op(input logic [4:0] rs, input logic [4:0] ra,
                          input logic [63:0] base, input logic [15:0] disp,
                          input int mode, input bit inject);
        logic [63:0] ea;
        int b0, d0, waited;
        ea = ((ra == 0) ? 64'd0 : base) + {{48{disp[15]}}, disp};
        for (int r = int'(rs); r < 32; r++) begin
            exp_t e;
            e.a = ea + 64'(4 * (r - int'(rs)));
            e.d = regs[r][31:0];
            e.last = (r == 31);
            expq.push_back(e);
        end
        rdy_mode = mode;
        b0 = beats;
        d0 = done_seen;
        @(negedge clk);
        first_reg_i = rs; base_sel_i = ra; base_val_i = base; disp_i = disp;
        little_end_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        first_reg_i = 5'd7; base_val_i = 64'hFFFF_0000_0000_0000;
        if (inject) begin
            repeat (2) @(negedge clk);
            first_reg_i = 5'd0; base_sel_i = 5'd0; disp_i = 16'h0100; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (done_seen == d0 && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        if (rs == 5'd31)
            check(beats - b0 == 1, "R8", "single-word beat count", 64'(beats - b0), 64'd1);
        check(beats - b0 == 32 - int'(rs), inject ? "R9" : "R2", "beat count",
              64'(beats - b0), 64'(32 - int'(rs)));
        check(expq.size() == 0, "R2", "expected queue drained", 64'(expq.size()), 64'd0);
    endtask

    task automatic run_le(input logic [4:0] rs);
        int b0;
        b0 = beats;
        @(negedge clk);
        first_reg_i = rs; base_sel_i = 5'd3; base_val_i = 64'h4000; disp_i = 16'h0;
        little_end_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        little_end_i = 1'b0;
        check(align_exc_o == 1'b1, "R6", "exception pulse", 64'(align_exc_o), 64'd1);
        check(wr_valid_o == 1'b0, "R6", "no write on exception", 64'(wr_valid_o), 64'd0);
        @(negedge clk);
        check(align_exc_o == 1'b0, "R6", "exception one cycle", 64'(align_exc_o), 64'd0);
        repeat (4) @(negedge clk);
        check(beats == b0, "R6", "no beats after exception", 64'(beats - b0), 64'd0);
    endtask

    task automatic summary;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = reg_val(i);
        repeat (3) @(negedge clk);
        check(!wr_valid_o && !done_o && !align_exc_o, "R10", "outputs in reset",
              {61'd0, wr_valid_o, done_o, align_exc_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid_o && !done_o && !align_exc_o, "R10", "outputs after reset",
              {61'd0, wr_valid_o, done_o, align_exc_o}, 64'd0);

        run_op(5'd28, 5'd5, 64'h1000, 16'h0010, 0, 0);                 // R1 base + disp
        run_op(5'd29, 5'd0, 64'h7777_0000, 16'hFFF8, 0, 0);            // R1 zero base, R4 wrap
        run_op(5'd31, 5'd2, 64'h2000, 16'h0004, 2, 0);                 // R8 single word, stalled
        run_op(5'd0, 5'd9, 64'h0000_0001_0000_0000, 16'h0040, 1, 0);   // R2 all registers
        run_le(5'd20);                                                 // R6
        run_op(5'd26, 5'd4, 64'h2000, 16'h8000, 2, 1);                 // R9 start while busy
        run_op(5'd24, 5'd1, 64'h0000_0000_0001_0000, 16'h7FFC, 1, 0);  // R5 stalls, R3 data
        summary();
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule